// File: doc/BRIEF.md
# Configurable UART transmitter with framing

This block is the transmit half of an asynchronous serial port. Software writes a character into a holding buffer through a byte-wide register port. On the next bit tick while the engine is idle, the block copies that character into a frame shift register and sends it on the line. It sends one start bit, then the data bits least significant first, then an optional extra bit, then one stop bit. The line rests high between frames. Bit timing comes entirely from a one-cycle `bit_tick` pulse supplied by an external baud generator. Every bit lasts exactly one tick period.

A two-bit length field in the control register selects the frame size. The options are seven, eight or nine data bits, or a nine-bit loopback mode. In loopback mode the serial stream goes to the internal receiver input instead of the pin. The extra bit after the data has two uses. In nine-bit modes it is the ninth data bit, taken from a control bit. In seven- and eight-bit modes it is an optional parity bit: odd, even, mark or space. The block reports three things to software: holding buffer empty, frame in progress, and a transmit interrupt that is gated by an enable bit. If the buffer is refilled while a frame is in flight, the next frame follows with no idle gap.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset `tx_pin` is 1, `buf_empty` is 1, `tx_busy` is 0, `tx_irq` is 0, and all control fields are 0. A `bit_tick` with an empty buffer leaves the line high and `tx_busy` low.
- R2: A write with `reg_sel`=1 stores `reg_wdata` in the holding buffer and clears `buf_empty` on the next clock. `buf_empty` returns to 1 on the clock edge where the buffer is copied into the shift register.
- R3: When the engine is idle and the buffer is full, the copy happens at the first `bit_tick`. From that edge the line shows the start bit (0). Each later `bit_tick` moves to the next bit. The last bit is a stop bit (1), and the line is 1 whenever no frame is in progress.
- R4: A write with `reg_sel`=0 sets the control fields. Bits [1:0] are the length code: 00 sends eight data bits, 01 sends the low seven bits, 10 sends nine data bits, and 11 sends nine data bits in loopback. Data bits go out least significant first.
- R5: In length codes 10 and 11, control bit 3 is sent as the ninth data bit. No parity bit is added in these modes, whatever bit 2 holds.
- R6: In length codes 00 and 01, control bit 2 enables a parity bit placed after the data and before the stop bit. The parity type is set by {bit 4, bit 3}: 00 odd, 01 even, 10 mark (always 1), 11 space (always 0). When bit 2 is 0, no parity bit is sent.
- R7: In length code 11, `rx_internal` carries the serial stream and `tx_pin` is held at 1. In every other mode `tx_pin` carries the serial stream and `rx_internal` follows `rx_pin`.
- R8: `tx_busy` is 1 from the clock edge that starts a frame until the `bit_tick` that ends the stop bit of the last frame.
- R9: `tx_irq` equals `buf_empty` AND control bit 5. When bit 5 is 0, `tx_irq` stays 0.
- R10: If the buffer is full when the `bit_tick` ending a stop bit arrives, the next frame's start bit begins on that same edge. `tx_busy` stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 holding buffer |
| reg_wdata | input | BYTE_W | Write data |
| rx_pin | input | 1 | External serial receive line |
| tx_pin | output | 1 | External serial transmit line |
| rx_internal | output | 1 | Receiver input: `rx_pin` normally, the serial stream in loopback |
| buf_empty | output | 1 | Holding buffer empty flag |
| tx_busy | output | 1 | Frame in progress |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
A register write takes effect on the next clock edge. Because of that, the bench checks `buf_empty` and `tx_irq` at the falling edge right after the write strobe. The serial line changes only on a clock edge where `bit_tick` is high, so the bench drives each tick for exactly one cycle and reads the line at the falling edge that follows. The reading is held for the rest of the bit period. Because `rx_internal` is a combinational path from `rx_pin`, the bench changes `rx_pin` between edges and reads `rx_internal` after a short delay, without waiting for a clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [1:0] {
      LEN_EIGHT = 2'b00,
      LEN_SEVEN = 2'b01,
      LEN_NINE  = 2'b10,
      LEN_LOOP  = 2'b11
   } len_mode_e;

   typedef enum logic [1:0] {
      PAR_ODD   = 2'b00,
      PAR_EVEN  = 2'b01,
      PAR_MARK  = 2'b10,
      PAR_SPACE = 2'b11
   } par_kind_e;

   // Control register layout, most significant field first.
   typedef struct packed {
      logic      irq_en;   // bit 5
      logic      sel_hi;   // bit 4
      logic      sel_lo;   // bit 3: ninth data bit or low parity select
      logic      par_en;   // bit 2
      len_mode_e len;      // bits 1:0
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
   import uart_tx_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [BYTE_W-1:0] reg_wdata,
   input  logic              load,
   output ctrl_t             ctrl,
   output logic [BYTE_W-1:0] hold,
   output logic              hold_empty
);

   logic wr_ctrl;
   logic wr_hold;

   assign wr_ctrl = reg_we && !reg_sel;
   assign wr_hold = reg_we && reg_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl       <= '0;
         hold       <= '0;
         hold_empty <= 1'b1;
      end else begin
         if (wr_ctrl) begin
            ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         end
         if (wr_hold) begin
            hold       <= reg_wdata;
            hold_empty <= 1'b0;
         end else if (load) begin
            hold_empty <= 1'b1;
         end
      end
   end

   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hold |=> !hold_empty); // R2
   AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr_hold) |=> hold_empty); // R2
   AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hold |=> $stable(hold)); // R2

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
   import uart_tx_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int FRAME_W = BYTE_W + 3,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  len_mode_e          len,
   input  logic               par_en,
   input  logic               sel_hi,
   input  logic               sel_lo,
   input  logic [BYTE_W-1:0]  hold,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   frame_len
);

   logic      nine;
   logic      seven;
   logic      ones_odd;
   logic      par_bit;
   logic      has_extra;
   logic      extra;
   logic      slot;
   par_kind_e kind;

   always_comb begin
      nine      = (len == LEN_NINE) || (len == LEN_LOOP);
      seven     = (len == LEN_SEVEN);
      ones_odd  = seven ? ^hold[BYTE_W-2:0] : ^hold;
      kind      = par_kind_e'({sel_hi, sel_lo});
      unique case (kind)
         PAR_ODD:   par_bit = ~ones_odd;
         PAR_EVEN:  par_bit = ones_odd;
         PAR_MARK:  par_bit = 1'b1;
         PAR_SPACE: par_bit = 1'b0;
         default:   par_bit = 1'b0;
      endcase
      has_extra = nine || par_en;
      extra     = nine ? sel_lo : par_bit;
      slot      = has_extra ? extra : 1'b1;
      if (seven) begin
         frame     = {2'b11, slot, hold[BYTE_W-2:0], 1'b0};
         frame_len = CNT_W'(BYTE_W + 1) + CNT_W'(has_extra);
      end else begin
         frame     = {1'b1, slot, hold, 1'b0};
         frame_len = CNT_W'(BYTE_W + 2) + CNT_W'(has_extra);
      end
   end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
   parameter int FRAME_W = 11,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_tick,
   input  logic               hold_empty,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   frame_len,
   output logic               load,
   output logic               serial,
   output logic               busy
);

   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   left;
   logic               last_bit;

   assign last_bit = busy && (left == CNT_W'(1));
   assign load     = bit_tick && !hold_empty && (!busy || last_bit);
   assign serial   = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         left <= '0;
         busy <= 1'b0;
      end else if (load) begin
         sh   <= frame;
         left <= frame_len;
         busy <= 1'b1;
      end else if (bit_tick && busy) begin
         if (last_bit) begin
            sh   <= '1;
            left <= '0;
            busy <= 1'b0;
         end else begin
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            left <= left - CNT_W'(1);
         end
      end
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> serial); // R3
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !serial); // R3
   AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_tick) |=> $stable(serial)); // R3
   AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (left != '0 && left <= CNT_W'(FRAME_W))); // R4
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last_bit) |=> busy); // R8

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_tx_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter bit REG_LINE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [BYTE_W-1:0] reg_wdata,
   input  logic              rx_pin,
   output logic              tx_pin,
   output logic              rx_internal,
   output logic              buf_empty,
   output logic              tx_busy,
   output logic              tx_irq
);

   localparam int FRAME_W = BYTE_W + 3;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (BYTE_W < CTRL_W) begin : g_bad_width
      $error("BYTE_W must hold every control field");
   end

   ctrl_t              ctrl;
   logic [BYTE_W-1:0]  hold;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   frame_len;
   logic               load;
   logic               serial;
   logic               line;
   logic               loopback;

   uart_tx_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .load       (load),
      .ctrl       (ctrl),
      .hold       (hold),
      .hold_empty (buf_empty)
   );

   uart_tx_frame #(.BYTE_W(BYTE_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
      .len       (ctrl.len),
      .par_en    (ctrl.par_en),
      .sel_hi    (ctrl.sel_hi),
      .sel_lo    (ctrl.sel_lo),
      .hold      (hold),
      .frame     (frame),
      .frame_len (frame_len)
   );

   uart_tx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_tick   (bit_tick),
      .hold_empty (buf_empty),
      .frame      (frame),
      .frame_len  (frame_len),
      .load       (load),
      .serial     (serial),
      .busy       (tx_busy)
   );

   if (REG_LINE) begin : g_line_flop
      logic line_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_q <= 1'b1;
         else        line_q <= serial;
      end
      assign line = line_q;
   end else begin : g_line_direct
      assign line = serial;
   end

   assign loopback    = (ctrl.len == LEN_LOOP);
   assign tx_pin      = loopback ? 1'b1 : line;
   assign rx_internal = loopback ? line : rx_pin;
   assign tx_irq      = buf_empty && ctrl.irq_en;

   AST_LOOP_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      loopback |-> tx_pin); // R7
   AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> buf_empty); // R9
   AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (load && tx_busy) |=> (tx_busy && !serial)); // R10

endmodule

// File: tb/test_uart_tx_framer.sv
module test_uart_tx_framer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       reg_we = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic       rx_pin = 1'b1;
   logic       tx_pin;
   logic       rx_internal;
   logic       buf_empty;
   logic       tx_busy;
   logic       tx_irq;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_tx_framer #(.BYTE_W(8), .REG_LINE(1'b0)) i_uart_tx_framer (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .reg_we(reg_we),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rx_pin(rx_pin),
      .tx_pin(tx_pin), .rx_internal(rx_internal), .buf_empty(buf_empty),
      .tx_busy(tx_busy), .tx_irq(tx_irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   // Called at a falling edge; returns at a falling edge.
   task automatic wr(input bit sel, input logic [7:0] d);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic tick();
      repeat (2) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
   endtask

   function automatic logic [15:0] build(input logic [1:0] len, input bit pe,
                                         input logic [1:0] pc, input logic [7:0] d,
                                         output int n, output bit has);
      logic [15:0] e;
      bit nine, seven, xb;
      int ones;
      nine  = len[1];
      seven = (len == 2'b01);
      ones  = seven ? $countones(d[6:0]) : $countones(d);
      case (pc)
         2'b00:   xb = (ones % 2 == 0);
         2'b01:   xb = (ones % 2 == 1);
         2'b10:   xb = 1'b1;
         default: xb = 1'b0;
      endcase
      if (nine) xb = pc[0];
      has = nine || pe;
      e = '1; e[0] = 1'b0; n = 1;
      for (int b = 0; b < (seven ? 7 : 8); b++) begin e[n] = d[b]; n++; end
      if (has) begin e[n] = xb; n++; end
      e[n] = 1'b1; n++;
      return e;
   endfunction

   // Checks one bit after its tick; k is the bit index within the frame.
   task automatic check_bit(input logic [15:0] e, input int k, input int n,
                            input bit has, input logic [1:0] len);
      bit loop;
      logic ln;
      string tag;
      loop = (len == 2'b11);
      rx_pin = k[0];
      #1;
      ln = loop ? rx_internal : tx_pin;
      if (k == 0 || k == n - 1)  tag = "R3";
      else if (has && k == n - 2) tag = len[1] ? "R5" : "R6";
      else                        tag = "R4";
      check(ln == e[k], tag, ln, e[k]);
      check(tx_busy == 1'b1, "R8", tx_busy, 1);
      if (loop) check(tx_pin == 1'b1, "R7", tx_pin, 1);
      else      check(rx_internal == rx_pin, "R7", rx_internal, rx_pin);
   endtask

   task automatic run_frame(input logic [1:0] len, input bit pe, input logic [1:0] pc,
                            input bit ie, input logic [7:0] d);
      logic [15:0] e;
      int n;
      bit has;
      e = build(len, pe, pc, d, n, has);
      wr(1'b0, {2'b00, ie, pc, pe, len});
      wr(1'b1, d);
      check(buf_empty == 1'b0, "R2", buf_empty, 0);
      check(tx_irq == 1'b0, "R9", tx_irq, 0);
      for (int k = 0; k < n; k++) begin
         tick();
         check_bit(e, k, n, has, len);
         if (k == 0) begin
            check(buf_empty == 1'b1, "R2", buf_empty, 1);
            check(tx_irq == ie, "R9", tx_irq, ie);
         end
      end
      tick();
      check(tx_busy == 1'b0, "R8", tx_busy, 0);
      check(tx_pin == 1'b1, "R3", tx_pin, 1);
      check(tx_irq == ie, "R9", tx_irq, ie);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(tx_pin == 1'b1, "R1", tx_pin, 1);
      check(buf_empty == 1'b1, "R1", buf_empty, 1);
      check(tx_busy == 1'b0, "R1", tx_busy, 0);
      check(tx_irq == 1'b0, "R1", tx_irq, 0);
      tick();
      check(tx_pin == 1'b1, "R1", tx_pin, 1);
      check(tx_busy == 1'b0, "R1", tx_busy, 0);

      // Sweep lengths, parity enable, select codes and data patterns (R4 R5 R6 R7)
      for (int len = 0; len < 4; len++)
         for (int pe = 0; pe < 2; pe++)
            for (int pc = 0; pc < 4; pc++)
               for (int di = 0; di < 6; di++)
                  run_frame(len[1:0], pe[0], pc[1:0], di[0],
                            8'((di * 8'h37) + (len * 13) + (pc * 5) + pe));

      // R10 back-to-back frames
      begin
         logic [15:0] ea, eb;
         int na, nb;
         bit ha, hb;
         ea = build(2'b00, 1'b1, 2'b01, 8'h3C, na, ha);
         eb = build(2'b00, 1'b1, 2'b01, 8'hC3, nb, hb);
         wr(1'b0, {2'b00, 1'b1, 2'b01, 1'b1, 2'b00});
         wr(1'b1, 8'h3C);
         tick();
         check_bit(ea, 0, na, ha, 2'b00);
         wr(1'b1, 8'hC3);
         check(buf_empty == 1'b0, "R2", buf_empty, 0);
         check(tx_irq == 1'b0, "R9", tx_irq, 0);
         for (int k = 1; k < na; k++) begin
            tick();
            check_bit(ea, k, na, ha, 2'b00);
         end
         tick();
         check(tx_pin == 1'b0, "R10", tx_pin, 0);
         check(tx_busy == 1'b1, "R10", tx_busy, 1);
         check(buf_empty == 1'b1, "R10", buf_empty, 1);
         for (int k = 1; k < nb; k++) begin
            tick();
            check_bit(eb, k, nb, hb, 2'b00);
         end
         tick();
         check(tx_busy == 1'b0, "R8", tx_busy, 0);
         check(tx_irq == 1'b1, "R9", tx_irq, 1);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog (all requirements): actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule